// File: doc/BRIEF.md
# Scanline Sprite Selector

This block decides which sprites take part in drawing the next scanline. A table of 64 vertical sprite positions, one byte each, is held in an internal memory. Software or a host engine loads this memory through a single write port. When the display pipeline is about to draw a line, it presents the line number and the global sprite height mode and pulses `start`. The block then walks the table one entry per clock, in ascending index order. It collects the indices of the sprites whose rows cover that line.

The search always occupies the same fixed window of clocks, whatever the table holds. At the end the block pulses `done`. At that point it presents a count of 0 to 8 and a packed list of selected indices, and both stay stable until the next accepted `start`. Only the first eight covering sprites, which are the lowest-numbered ones, are kept. A further covering sprite sets a sticky overflow flag. A table entry holding the end-of-list marker value stops the search early, and every entry after it is ignored.

Top module: `sprite_line_select`

## Requirements
- R1: After reset, `done`, `sel_count`, `sel_list` and `ovf` are all zero.
- R2: Entry i covers the line when (line − Y[i]) mod 256 is less than the sprite height. The height is 8 lines when `tall_mode` is 0 and 16 lines when it is 1.
- R3: At most 8 sprites are selected for a line. When more than 8 cover it, the 8 lowest indices are kept and the higher ones are dropped.
- R4: Selected indices appear in ascending order. Slot k sits in `sel_list[k*6 +: 6]`, slot 0 holds the lowest selected index, and slots at or above `sel_count` read zero.
- R5: `ovf` goes to 1 when a covering sprite is found while 8 are already selected. It then stays at 1 across later searches until a `clr_ovf` pulse clears it.
- R6: `done` is high for exactly one cycle, 65 clock edges after the edge that samples `start`. The timing does not depend on the table contents, and `sel_count` and `sel_list` hold their values until the next accepted `start`.
- R7: An entry equal to 0xD0 ends the search. That entry is not selected, and no entry after it is selected or counted toward overflow.
- R8: `line_no` and `tall_mode` are captured at the accepted `start`, so later changes do not affect the result. A `start` that arrives while a search is still running is ignored.
- R9: A write with `y_we` high stores `y_wdata` in entry `y_waddr`, and later searches use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| y_we | input | 1 | Write enable for the Y table |
| y_waddr | input | 6 | Entry index to write |
| y_wdata | input | 8 | Vertical position to store |
| start | input | 1 | One-cycle pulse that begins a search |
| line_no | input | 8 | Line to be searched |
| tall_mode | input | 1 | 0: 8-line sprites, 1: 16-line sprites |
| clr_ovf | input | 1 | Clears the overflow flag |
| done | output | 1 | One-cycle pulse when the result is ready |
| sel_count | output | 4 | Number of selected sprites, 0 to 8 |
| sel_list | output | 48 | Eight 6-bit index slots, slot 0 in the low bits |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench places sprites exactly one row inside and one row outside each height, and places others whose coverage exists only through wraparound past 255. A design with an off-by-one compare, or one that uses signed or unwrapped subtraction, would miss or add those entries. Twelve sprites are stacked on a single line so that a cap that keeps the wrong sprites, an overflow that does not latch, or a flag that clears on its own would show in the list or in `ovf`. The test also places a 0xD0 marker in the middle of covering entries, and it changes the line input and repeats `start` during a running search. A design that selected the marker, kept scanning past it, or restarted on the second `start` would report the wrong list or an extra `done`.

// File: rtl/sprsel_pkg.sv
package sprsel_pkg;
  localparam int YW = 8;
  typedef enum logic {HT_SHORT = 1'b0, HT_TALL = 1'b1} hmode_e;
endpackage

// File: rtl/sprsel_ymem.sv
// Y position table: one write port and a registered read port, so it maps to block RAM.
module sprsel_ymem #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sprsel_cover.sv
// Decides, for one table entry, whether it covers the line and whether it is the end marker.
module sprsel_cover #(
  parameter int DW     = 8,
  parameter int H_LO   = 8,
  parameter int H_HI   = 16,
  parameter int TERM_Y = 208
) (
  input  logic [DW-1:0] line_no,
  input  logic [DW-1:0] ypos,
  input  logic          tall,
  output logic          hit,
  output logic          term
);
  localparam logic [DW-1:0] HLO_V  = DW'(H_LO);
  localparam logic [DW-1:0] HHI_V  = DW'(H_HI);
  localparam logic [DW-1:0] TERM_V = DW'(TERM_Y);

  logic [DW-1:0] diff;
  logic [DW-1:0] height;

  always_comb begin
    diff   = line_no - ypos;
    height = tall ? HHI_V : HLO_V;
    hit    = diff < height;
    term   = ypos == TERM_V;
  end
endmodule

// File: rtl/sprsel_seq.sv
// Scan sequencer: accepts start, steps through every entry once, and tags the read data.
module sprsel_seq
  import sprsel_pkg::*;
#(
  parameter int NSPR = 64,
  parameter int IW   = 6,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] line_in,
  input  logic          tall_in,
  output logic [IW-1:0] rd_addr,
  output logic          v_valid,
  output logic [IW-1:0] v_idx,
  output logic          v_last,
  output logic          clear,
  output logic [DW-1:0] line_q,
  output hmode_e        tall_q
);
  localparam logic [IW-1:0] LAST = IW'(NSPR - 1);

  logic          busy;
  logic [IW-1:0] scan;

  assign clear   = start && !busy && !v_valid;
  assign rd_addr = scan;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      scan    <= '0;
      v_valid <= 1'b0;
      v_idx   <= '0;
      v_last  <= 1'b0;
      line_q  <= '0;
      tall_q  <= HT_SHORT;
    end else begin
      v_valid <= busy;
      v_idx   <= scan;
      v_last  <= busy && (scan == LAST);
      if (clear) begin
        busy   <= 1'b1;
        scan   <= '0;
        line_q <= line_in;
        tall_q <= hmode_e'(tall_in);
      end else if (busy) begin
        scan <= scan + 1'b1;
        if (scan == LAST) busy <= 1'b0;
      end
    end
  end

  // R8: the captured line stays fixed for the whole scan
  p_line_hold_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(line_q));
  // R6: a scan that has not reached the last entry keeps running
  p_scan_run_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && scan != LAST) |=> busy);
endmodule

// File: rtl/sprsel_collect.sv
// Result collector: fills the slots in order, applies the cap, end marker and overflow.
module sprsel_collect #(
  parameter int MAXN = 8,
  parameter int IW   = 6,
  parameter int CW   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               v_valid,
  input  logic               v_last,
  input  logic [IW-1:0]      v_idx,
  input  logic               hit,
  input  logic               term,
  input  logic               clr_ovf,
  output logic               done,
  output logic [CW-1:0]      count,
  output logic [MAXN*IW-1:0] list,
  output logic               ovf
);
  localparam logic [CW-1:0] FULL = CW'(MAXN);

  logic          stopped;
  logic          live, push, spill;
  logic [IW-1:0] last_idx;

  assign live  = v_valid && !stopped && !term;
  assign push  = live && hit && (count != FULL);
  assign spill = live && hit && (count == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      count    <= '0;
      stopped  <= 1'b0;
      ovf      <= 1'b0;
      last_idx <= '0;
    end else begin
      done <= v_valid && v_last;
      if (clear) begin
        count   <= '0;
        stopped <= 1'b0;
      end else begin
        if (v_valid && !stopped && term) stopped <= 1'b1;
        if (push) begin
          count    <= count + 1'b1;
          last_idx <= v_idx;
        end
      end
      if (spill)        ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;
    end
  end

  for (genvar k = 0; k < MAXN; k++) begin : g_slot
    logic [IW-1:0] slot;
    always_ff @(posedge clk) begin
      if (rst || clear)                    slot <= '0;
      else if (push && count == CW'(k))    slot <= v_idx;
    end
    assign list[k*IW +: IW] = slot;
  end

  // R3: never more than the cap
  p_cap_r3: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  // R4: each new index is above the previous one
  p_order_r4: assert property (@(posedge clk) disable iff (rst)
    (push && count != '0) |-> (v_idx > last_idx));
  // R5: overflow is sticky until cleared
  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_ovf) |=> ovf);
  // R6: done lasts a single cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7: nothing is added once the end marker has been seen
  p_after_term_r7: assert property (@(posedge clk) disable iff (rst)
    (stopped && !clear) |=> $stable(count));
endmodule

// File: rtl/sprite_line_select.sv
module sprite_line_select
  import sprsel_pkg::*;
#(
  parameter int NSPR   = 64,
  parameter int MAXN   = 8,
  parameter int H_LO   = 8,
  parameter int H_HI   = 16,
  parameter int TERM_Y = 208,
  localparam int IW    = $clog2(NSPR),
  localparam int CW    = $clog2(MAXN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               y_we,
  input  logic [IW-1:0]      y_waddr,
  input  logic [YW-1:0]      y_wdata,
  input  logic               start,
  input  logic [YW-1:0]      line_no,
  input  logic               tall_mode,
  input  logic               clr_ovf,
  output logic               done,
  output logic [CW-1:0]      sel_count,
  output logic [MAXN*IW-1:0] sel_list,
  output logic               ovf
);
  logic [IW-1:0] rd_addr, v_idx;
  logic          v_valid, v_last, clear;
  logic [YW-1:0] line_q, ydata;
  hmode_e        tall_q;
  logic          hit, term;

  sprsel_seq #(.NSPR(NSPR), .IW(IW), .DW(YW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .line_in(line_no), .tall_in(tall_mode),
    .rd_addr(rd_addr), .v_valid(v_valid), .v_idx(v_idx), .v_last(v_last),
    .clear(clear), .line_q(line_q), .tall_q(tall_q)
  );

  sprsel_ymem #(.DEPTH(NSPR), .AW(IW), .DW(YW)) u_mem (
    .clk(clk), .we(y_we), .waddr(y_waddr), .wdata(y_wdata),
    .raddr(rd_addr), .rdata(ydata)
  );

  sprsel_cover #(.DW(YW), .H_LO(H_LO), .H_HI(H_HI), .TERM_Y(TERM_Y)) u_cov (
    .line_no(line_q), .ypos(ydata), .tall(tall_q == HT_TALL),
    .hit(hit), .term(term)
  );

  sprsel_collect #(.MAXN(MAXN), .IW(IW), .CW(CW)) u_col (
    .clk(clk), .rst(rst), .clear(clear), .v_valid(v_valid), .v_last(v_last),
    .v_idx(v_idx), .hit(hit), .term(term), .clr_ovf(clr_ovf),
    .done(done), .count(sel_count), .list(sel_list), .ovf(ovf)
  );
endmodule

// File: tb/sim_sprite_line_select.sv
module sim_sprite_line_select;
  typedef struct packed {
    logic [3:0]  cnt;
    logic [47:0] lst;
    logic        ov;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        y_we = 1'b0;
  logic [5:0]  y_waddr = '0;
  logic [7:0]  y_wdata = '0;
  logic        start = 1'b0;
  logic [7:0]  line_no = '0;
  logic        tall_mode = 1'b0;
  logic        clr_ovf = 1'b0;
  logic        done;
  logic [3:0]  sel_count;
  logic [47:0] sel_list;
  logic        ovf;

  always #10 clk = ~clk;

  sprite_line_select u0 (
    .clk(clk), .rst(rst), .y_we(y_we), .y_waddr(y_waddr), .y_wdata(y_wdata),
    .start(start), .line_no(line_no), .tall_mode(tall_mode), .clr_ovf(clr_ovf),
    .done(done), .sel_count(sel_count), .sel_list(sel_list), .ovf(ovf)
  );

  int   cyc = 0;
  int   vectors = 0;
  int   miscompares = 0;
  int   t_start = 0;
  logic [7:0] ytab [64];
  logic model_ovf = 1'b0;
  exp_t q[$];
  logic prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: compares each done against the scoreboard head
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) chk(0, "R6", "done wider than one cycle", 1, 0);
      if (done && !prev_done) begin
        if (q.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc - t_start == 65, "R6", "done latency", 64'(cyc - t_start), 65);
          chk(sel_count == e.cnt, "R3", "count", 64'(sel_count), 64'(e.cnt));
          chk(sel_list == e.lst, "R4", "list", 64'(sel_list), 64'(e.lst));
          chk(ovf == e.ov, "R5", "overflow", 64'(ovf), 64'(e.ov));
        end
      end
      prev_done <= done;
    end
  end

  task automatic wr(input int idx, input logic [7:0] y);
    @(negedge clk);
    y_we = 1'b1; y_waddr = 6'(idx); y_wdata = y;
    ytab[idx] = y;
    @(negedge clk);
    y_we = 1'b0;
  endtask

  // driver: computes the expected result and pushes it before starting
  task automatic search(input logic [7:0] ln, input logic th,
                        input bit alt_line, input bit restart);
    exp_t e;
    logic [7:0] d;
    bit stop = 0;
    e = '0;
    for (int i = 0; i < 64; i++) begin
      if (!stop) begin
        d = ln - ytab[i];
        if (ytab[i] == 8'hD0) stop = 1;
        else if (d < (th ? 8'd16 : 8'd8)) begin
          if (e.cnt < 8) begin
            e.lst[e.cnt*6 +: 6] = 6'(i);
            e.cnt = e.cnt + 1'b1;
          end else model_ovf = 1'b1;
        end
      end
    end
    e.ov = model_ovf;
    q.push_back(e);
    @(negedge clk);
    line_no = ln; tall_mode = th; start = 1'b1;
    @(negedge clk);
    t_start = cyc;
    start = 1'b0;
    if (alt_line) begin
      line_no = ln + 8'd45; tall_mode = ~th;
    end
    repeat (9) @(negedge clk);
    if (restart) begin
      line_no = ln + 8'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (70) @(negedge clk);
    chk(q.size() == 0, "R8", "pending results", 64'(q.size()), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && sel_count == 0, "R1", "done/count after reset",
        {sel_count, done}, 0);
    chk(sel_list == 0, "R1", "list after reset", 64'(sel_list), 0);
    chk(ovf == 0, "R1", "ovf after reset", 64'(ovf), 0);

    for (int i = 0; i < 64; i++) wr(i, 8'hE0);
    search(8'd10, 1'b0, 0, 0);                     // R2: nothing covers

    wr(3, 8'd93); wr(4, 8'd92); wr(9, 8'd100);     // R2: height edges
    wr(10, 8'd101); wr(11, 8'd85); wr(12, 8'd84);
    search(8'd100, 1'b0, 0, 0);
    search(8'd100, 1'b1, 0, 0);

    wr(20, 8'd250); wr(21, 8'd252);                // R2: wraparound
    search(8'd3, 1'b0, 0, 0);
    search(8'd3, 1'b1, 0, 0);
    wr(21, 8'hE0);                                 // R9: rewrite takes effect
    search(8'd3, 1'b0, 0, 0);

    for (int i = 30; i < 42; i++) wr(i, 8'd50);    // R3/R5: twelve on one line
    search(8'd55, 1'b0, 0, 0);
    search(8'd10, 1'b0, 0, 0);                     // R5: flag stays set
    @(negedge clk);
    clr_ovf = 1'b1;
    @(negedge clk);
    clr_ovf = 1'b0;
    model_ovf = 1'b0;
    chk(ovf == 0, "R5", "ovf after clear", 64'(ovf), 0);

    wr(33, 8'hD0);                                 // R7: end marker mid-run
    search(8'd55, 1'b0, 0, 0);
    search(8'd208, 1'b1, 0, 0);                    // R7: marker never selected
    search(8'd55, 1'b0, 1, 0);                     // R8: inputs change mid-scan
    search(8'd55, 1'b1, 0, 1);                     // R8: start while busy

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule